// File: doc/BRIEF.md
# Three-Channel Reload Timer Unit

This block provides three independent 32-bit down-counters for a peripheral subsystem. Software programs each channel through a small register window: a reload value, the live count and a control word that picks the count tick and enables the interrupt. A shared run register starts and stops the channels one bit each. A running channel steps down once per selected tick. The tick is either a power-of-four division of a peripheral clock enable, a real-time-clock pulse or an external pulse.

When a channel steps from zero, it reloads from its reload register instead of wrapping. It also raises a sticky underflow flag. If the channel's interrupt enable is set, the flag drives that channel's interrupt line as a level until software clears the flag. Reads return data one clock after the address is presented. Writes take effect on the clock edge where `wr_en` is high.

Top module: `reload_timer_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0, every channel is stopped, `rdata` is 0 and `irq` is 0.
- R2: The run register is at byte address 0x00, with bit i running channel i. Channel i owns three registers starting at 0x04 + 12*i: reload at +0, count at +4 and control at +8. `rdata` shows the register addressed on the previous cycle. An unmapped address reads 0.
- R3: Control bits [2:0] choose the tick. Codes 0 to 4 give one tick per 4, 16, 64, 256 or 1024 enabled `pclk_en` cycles. The first tick comes on the division-th enabled cycle after the run bit rises, and each tick lowers the count by one.
- R4: Control code 5 is treated as one tick per 4096 enabled `pclk_en` cycles.
- R5: Code 6 counts `rtc_tick` and code 7 counts `ext_tick`, one step per cycle in which the pulse is high and the channel runs. A source that is not selected has no effect on the count.
- R6: A tick while the count is 0 loads the reload value into the count and sets control bit 8, the underflow flag.
- R7: The underflow flag is sticky. A control write with bit 8 = 0 clears it, and a write with bit 8 = 1 leaves it as it was. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: `irq[i]` is high on the cycle after channel i has both control bit 5 (interrupt enable) and the underflow flag set. It is low on the cycle after either of them is 0.
- R9: Control bit 9 stores whatever is written to it and has no other effect. Control bits other than 0-2, 5, 8 and 9 read 0.
- R10: When a run bit goes from 0 to 1, the channel's residual prescaler count is cleared. A stopped channel holds its count. A count write is always accepted, and it replaces any tick of the same cycle, so no underflow occurs in that cycle.
- R11: Channels do not interact: traffic, ticks and underflows of one channel never change another channel's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_en | input | 1 | Peripheral clock enable, prescaler input |
| rtc_tick | input | 1 | Real-time-clock tick pulse |
| ext_tick | input | 1 | External tick pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt level |

## Verification
Directed sequences step a channel one enabled `pclk_en` cycle at a time across its first division boundary. This separates a correct divider from one that is off by one cycle. They also stop and restart a channel mid-period, which shows whether the residual prescaler count is cleared. The illegal code is run to 4095 and 4096 cycles to tell divide-by-4096 apart from any shorter division. Pulses on the unselected real-time and external sources show that those sources are ignored. Random register writes, some landing in the same cycle as ticks, are mixed with random tick densities on all three sources and compared against a cycle model. This exposes errors in write/tick priority, flag stickiness and channel crosstalk.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  localparam int SEL_W    = 3;
  localparam int IE_BIT   = 5;
  localparam int UF_BIT   = 8;
  localparam int ICF_BIT  = 9;
  localparam int PRE_W    = 12;
  localparam logic [SEL_W-1:0] CODE_RTC = 3'd6;
  localparam logic [SEL_W-1:0] CODE_EXT = 3'd7;
  localparam int GRP_BASE = 4;
  localparam int GRP_STRIDE = 12;
endpackage

// File: rtl/rtu_prescale.sv
module rtu_prescale
  import rtu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic             pclk_en,
  input  logic             rtc_tick,
  input  logic             ext_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [3:0]       shift;
  logic [PRE_W-1:0] mask;
  logic             full;

  // codes 0..5 map to 2,4,..,12 low bits of the residual count
  always_comb begin
    shift = {sel, 1'b0} + 4'd2;
    mask  = ~({PRE_W{1'b1}} << shift);
    full  = &(pre_q | ~mask);
    unique case (sel)
      CODE_RTC: tick = run & rtc_tick;
      CODE_EXT: tick = run & ext_tick;
      default:  tick = run & pclk_en & full;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                pre_q <= '0;
    else if (clr)           pre_q <= '0;
    else if (run & pclk_en) pre_q <= pre_q + 1'b1;
  end

  // R10: a start edge leaves no residual count
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0));
  // R10: a stopped channel never ticks
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/rtu_channel.sv
module rtu_channel
  import rtu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rld_we,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic [SEL_W-1:0] w_sel,
  input  logic             w_ie,
  input  logic             w_uf,
  input  logic             w_icf,
  output logic [CNT_W-1:0] rld_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             ie_q,
  output logic             uf_q,
  output logic             icf_q,
  output logic             irq_q
);
  logic underflow;

  assign underflow = tick & ~cnt_we & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q <= '0;
      cnt_q <= '0;
      sel_q <= '0;
      ie_q  <= 1'b0;
      uf_q  <= 1'b0;
      icf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (rld_we) rld_q <= wdata;
      if (cnt_we)         cnt_q <= wdata;
      else if (underflow) cnt_q <= rld_q;
      else if (tick)      cnt_q <= cnt_q - 1'b1;
      if (ctl_we) begin
        sel_q <= w_sel;
        ie_q  <= w_ie;
        icf_q <= w_icf;
        uf_q  <= underflow | (uf_q & w_uf);
      end else begin
        uf_q  <= uf_q | underflow;
      end
      irq_q <= uf_q & ie_q;
    end
  end

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && cnt_q == '0) |=> (cnt_q == $past(rld_q)) && uf_q);
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_we) |=> $stable(cnt_q));
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (uf_q && !ctl_we) |=> uf_q);
  p_irq_high_r8: assert property (@(posedge clk) disable iff (rst)
    (uf_q && ie_q) |=> irq_q);
  p_irq_low_r8: assert property (@(posedge clk) disable iff (rst)
    !(uf_q && ie_q) |=> !irq_q);
endmodule

// File: rtl/reload_timer_unit.sv
module reload_timer_unit
  import rtu_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk_en,
  input  logic              rtc_tick,
  input  logic              ext_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [ADDR_W-1:0] RUN_ADDR = '0;

  logic [NUM_CH-1:0] run_q;
  logic              run_we;
  logic [CNT_W-1:0]  rld_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a [NUM_CH];
  logic [CNT_W-1:0]  ctl_a [NUM_CH];
  logic [NUM_CH-1:0] hit_rld, hit_cnt, hit_ctl;
  logic [CNT_W-1:0]  rd_next;

  assign run_we = wr_en & (addr == RUN_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (run_we) run_q <= wdata[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(GRP_BASE + GRP_STRIDE * g);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(GRP_BASE + GRP_STRIDE * g + 4);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(GRP_BASE + GRP_STRIDE * g + 8);

    logic             tick, start_edge;
    logic [SEL_W-1:0] sel;
    logic             ie, uf, icf;

    assign hit_rld[g]  = addr == A_RLD;
    assign hit_cnt[g]  = addr == A_CNT;
    assign hit_ctl[g]  = addr == A_CTL;
    assign start_edge  = run_we & wdata[g] & ~run_q[g];

    rtu_prescale u_pre (
      .clk      (clk),
      .rst      (rst),
      .run      (run_q[g]),
      .clr      (start_edge),
      .pclk_en  (pclk_en),
      .rtc_tick (rtc_tick),
      .ext_tick (ext_tick),
      .sel      (sel),
      .tick     (tick)
    );

    rtu_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .rld_we (wr_en & hit_rld[g]),
      .cnt_we (wr_en & hit_cnt[g]),
      .ctl_we (wr_en & hit_ctl[g]),
      .wdata  (wdata),
      .w_sel  (wdata[SEL_W-1:0]),
      .w_ie   (wdata[IE_BIT]),
      .w_uf   (wdata[UF_BIT]),
      .w_icf  (wdata[ICF_BIT]),
      .rld_q  (rld_a[g]),
      .cnt_q  (cnt_a[g]),
      .sel_q  (sel),
      .ie_q   (ie),
      .uf_q   (uf),
      .icf_q  (icf),
      .irq_q  (irq[g])
    );

    always_comb begin
      ctl_a[g]          = '0;
      ctl_a[g][SEL_W-1:0] = sel;
      ctl_a[g][IE_BIT]  = ie;
      ctl_a[g][UF_BIT]  = uf;
      ctl_a[g][ICF_BIT] = icf;
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == RUN_ADDR) rd_next[NUM_CH-1:0] = run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_rld[i]) rd_next = rld_a[i];
      if (hit_cnt[i]) rd_next = cnt_a[i];
      if (hit_ctl[i]) rd_next = ctl_a[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R2: an address that selects nothing returns zero on the next cycle
  p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
    (addr != RUN_ADDR && hit_rld == '0 && hit_cnt == '0 && hit_ctl == '0)
      |=> (rdata == '0));
endmodule

// File: tb/reload_timer_unit_tb_top.sv
module reload_timer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pclk_en = 1'b0, rtc_tick = 1'b0, ext_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  always #2.5 clk = ~clk;

  reload_timer_unit dut_i (
    .clk(clk), .rst(rst), .pclk_en(pclk_en), .rtc_tick(rtc_tick),
    .ext_tick(ext_tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model, stepped from the requirements
  logic [31:0] m_rld [3];
  logic [31:0] m_cnt [3];
  logic [2:0]  m_sel [3];
  logic        m_ie [3], m_uf [3], m_icf [3], m_irq [3];
  int          m_pre [3];
  logic [2:0]  m_run;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_rld[i] = 0; m_cnt[i] = 0; m_sel[i] = 0; m_ie[i] = 0;
        m_uf[i] = 0; m_icf[i] = 0; m_irq[i] = 0; m_pre[i] = 0;
      end
      m_run = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        int  dv;
        bit  tk, uf, hr, hn, hc, se;
        dv = 4 << (2 * int'(m_sel[i]));
        if (m_sel[i] == 3'd6)      tk = m_run[i] && rtc_tick;
        else if (m_sel[i] == 3'd7) tk = m_run[i] && ext_tick;
        else tk = m_run[i] && pclk_en && ((m_pre[i] % dv) == dv - 1);
        hr = wr_en && (int'(addr) == 4 + 12 * i);
        hn = wr_en && (int'(addr) == 8 + 12 * i);
        hc = wr_en && (int'(addr) == 12 + 12 * i);
        se = wr_en && (addr == 0) && wdata[i] && !m_run[i];
        uf = tk && !hn && (m_cnt[i] == 0);
        m_irq[i] = m_uf[i] && m_ie[i];
        if (hn)      m_cnt[i] = wdata;
        else if (uf) m_cnt[i] = m_rld[i];
        else if (tk) m_cnt[i] = m_cnt[i] - 1;
        if (hc) begin
          m_uf[i]  = uf || (m_uf[i] && wdata[8]);
          m_sel[i] = wdata[2:0]; m_ie[i] = wdata[5]; m_icf[i] = wdata[9];
        end else m_uf[i] = m_uf[i] || uf;
        if (hr) m_rld[i] = wdata;
        if (se) m_pre[i] = 0;
        else if (m_run[i] && pclk_en) m_pre[i] = (m_pre[i] + 1) % 4096;
      end
      if (wr_en && addr == 0) m_run = wdata[2:0];
    end
  end

  function automatic logic [31:0] ctl_word(int i);
    return {22'd0, m_icf[i], m_uf[i], 2'b00, m_ie[i], 2'b00, m_sel[i]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; wr_en = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic freeze();
    @(negedge clk); pclk_en = 0; rtc_tick = 0; ext_tick = 0;
  endtask

  task automatic pclk_n(input int n);
    @(negedge clk); pclk_en = 1;
    repeat (n) @(negedge clk);
    pclk_en = 0;
  endtask

  task automatic rtc_n(input int n);
    @(negedge clk); rtc_tick = 1;
    repeat (n) @(negedge clk);
    rtc_tick = 0;
  endtask

  task automatic ext_n(input int n);
    @(negedge clk); ext_tick = 1;
    repeat (n) @(negedge clk);
    ext_tick = 0;
  endtask

  task automatic cmp_all(input string tag);
    logic [31:0] d;
    freeze();
    for (int i = 0; i < 3; i++) begin
      rd(6'(4 + 12 * i), d);  check({tag, " reload"}, d, m_rld[i]);
      rd(6'(8 + 12 * i), d);  check({tag, " count"}, d, m_cnt[i]);
      rd(6'(12 + 12 * i), d); check({tag, " control"}, d, ctl_word(i));
    end
    rd(6'd0, d); check({tag, " run"}, d, {29'd0, m_run});
    check({tag, " irq R8"}, {29'd0, irq}, {29'd0, m_irq[2], m_irq[1], m_irq[0]});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    for (int a = 0; a < 40; a += 4) begin
      rd(6'(a), d); check("R1 reset register", d, 0);
    end
    check("R1 reset irq", {29'd0, irq}, 0);

    // R2 map, R9 control field layout
    wr(6'h10, 32'h1234_5678); rd(6'h10, d); check("R2 ch1 reload", d, 32'h1234_5678);
    wr(6'h20, 32'h0000_CAFE); rd(6'h20, d); check("R2 ch2 count", d, 32'h0000_CAFE);
    rd(6'h28, d); check("R2 unmapped", d, 0);
    rd(6'h3C, d); check("R2 unmapped high", d, 0);
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, d); check("R9 control bits", d, 32'h0000_0227);
    check("R9 icf no irq", {29'd0, irq}, 0);

    // R3 divide by 4, first tick on the 4th enabled cycle
    wr(6'h0C, 32'h20); wr(6'h08, 2); wr(6'h04, 5); wr(6'h00, 1);
    pclk_n(3); rd(6'h08, d); check("R3 before first tick", d, 2);
    pclk_n(1); rd(6'h08, d); check("R3 first tick", d, 1);
    pclk_n(4); rd(6'h08, d); check("R3 second tick", d, 0);
    pclk_n(4); rd(6'h08, d); check("R6 reload", d, 5);
    rd(6'h0C, d); check("R6 flag set", d, 32'h120);
    check("R8 irq high", {31'd0, irq[0]}, 1);

    // R7 sticky flag
    wr(6'h0C, 32'h120); rd(6'h0C, d); check("R7 write one keeps", d, 32'h120);
    wr(6'h0C, 32'h020); rd(6'h0C, d); check("R7 write zero clears", d, 32'h020);
    check("R8 irq low", {31'd0, irq[0]}, 0);

    // R10 hold while stopped, residual cleared on restart
    wr(6'h00, 0); wr(6'h08, 3);
    pclk_n(10); rd(6'h08, d); check("R10 stopped hold", d, 3);
    wr(6'h00, 1); pclk_n(2); wr(6'h00, 0); wr(6'h00, 1);
    pclk_n(3); rd(6'h08, d); check("R10 residual cleared", d, 3);
    pclk_n(1); rd(6'h08, d); check("R10 tick after clear", d, 2);

    // R4 illegal code divides by 4096
    wr(6'h18, 5); wr(6'h14, 1); wr(6'h00, 3'b010);
    pclk_n(4095); rd(6'h14, d); check("R4 before 4096", d, 1);
    pclk_n(1); rd(6'h14, d); check("R4 at 4096", d, 0);

    // R5 source selection
    wr(6'h24, 6); wr(6'h20, 10); wr(6'h00, 3'b100);
    rtc_n(3); rd(6'h20, d); check("R5 rtc counts", d, 7);
    ext_n(2); rd(6'h20, d); check("R5 ext ignored", d, 7);
    pclk_n(8); rd(6'h20, d); check("R5 pclk ignored", d, 7);
    wr(6'h24, 7); ext_n(2); rd(6'h20, d); check("R5 ext counts", d, 5);
    rtc_n(2); rd(6'h20, d); check("R5 rtc ignored", d, 5);
    rd(6'h14, d); check("R11 ch1 untouched", d, 0);
    cmp_all("R11 directed");

    // constrained random against the model
    for (int it = 0; it < 300; it++) begin
      int nc;
      for (int w = 0; w < 1 + $urandom % 3; w++) begin
        int ch, kind;
        logic [31:0] v;
        ch = $urandom % 3; kind = $urandom % 4;
        @(negedge clk);
        pclk_en = ($urandom % 10) < 7; rtc_tick = ($urandom % 5) == 0;
        ext_tick = ($urandom % 5) == 0;
        if (kind == 3) begin addr = 0; v = $urandom % 8; end
        else if (kind == 2) begin
          addr = 6'(12 + 12 * ch); v = $urandom;
          if (v[2:0] == 3'd5) v[2:0] = 3'd4;
        end else begin addr = 6'(4 + 4 * kind + 12 * ch); v = $urandom % 24; end
        wdata = v; wr_en = 1;
        @(negedge clk); wr_en = 0;
      end
      nc = $urandom % 48;
      for (int c = 0; c < nc; c++) begin
        @(negedge clk);
        pclk_en = ($urandom % 10) < 7; rtc_tick = ($urandom % 4) == 0;
        ext_tick = ($urandom % 4) == 0;
      end
      if (it % 10 == 9) cmp_all("R11 random");
    end
    cmp_all("R6 R7 final");
    summary();
  end
endmodule